// File: doc/BRIEF.md
# Serial wire debug line-reset and select-sequence detector

This block watches the clock and data lines of a two-wire serial debug link for two events outside normal transactions. Both lines have already been brought into the system clock domain. The first event is a line reset: a long run of debug-clock rising edges with the data line held high, ended by an edge that samples a low. The second is the 16-bit switch-to-serial-wire selection pattern 0xE79E, which is shifted in least significant bit first on debug-clock rising edges.

Each event produces a single system-clock pulse. A line reset also reports the length of the high run that caused it. A transaction monitor next to this block uses either pulse to return to idle, whatever state it is in. The block does not decode transactions and never drives the link.

Top module: `swd_oob_detect`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `line_reset_o` and `select_o` are 0 and `run_len_o` is 0.
- R2: Only a debug-clock rising edge samples the data line. That edge is a system clock cycle in which `swclk_i` is 1 and it was 0 in the previous cycle. Changes on `swdio_i` while `swclk_i` does not rise have no effect on the high-run count or on the pattern history.
- R3: A rising edge that samples `swdio_i`=0 raises `line_reset_o` if at least RESET_MIN (default 50) consecutive rising edges since the last low sample saw `swdio_i`=1. Every low sample clears the high-run count, whether or not a line reset is raised.
- R4: Together with a line-reset pulse, `run_len_o` gives the high-run count that caused it. The count saturates at 2**CNT_W-1 (default 255). `run_len_o` holds its value until the next line reset.
- R5: `select_o` is raised when the last 16 sampled bits, oldest in bit 0, equal 0xE79E. Bits only count if they were sampled after reset was released. A run of 15 bits that follows reset and is shifted in over a zero history does not match.
- R6: Each pulse lasts exactly one system clock cycle. It appears in the cycle after the clock edge at which the debug-clock rise is seen.
- R7: `line_reset_o` and `select_o` are never high in the same cycle. A line reset takes priority.
- R8: A line reset discards all earlier pattern bits. The low bit that ended the high run is kept as the first bit of the new history, so a selection pattern that starts on that bit can still match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swclk_i | input | 1 | Synchronised debug clock |
| swdio_i | input | 1 | Synchronised debug data |
| line_reset_o | output | 1 | One-cycle line-reset pulse |
| select_o | output | 1 | One-cycle selection-pattern pulse |
| run_len_o | output | CNT_W | High-run length of the latest line reset |

## Verification
The checker's properties cover the behaviour that holds on every cycle:
- both pulses last one cycle and never overlap;
- a line reset follows a low-data rising edge;
- a selection pulse follows a rising edge that sampled the pattern's last bit;
- the reported run length is at least the threshold and stays still between resets.

Some behaviour only the bench's scenarios can show. A sweep of every run length from 0 to 60 places the threshold exactly. A 300-edge run shows saturation. Data toggled with the clock held still leaves the count unchanged, and the 15-bit partial pattern after reset does not match. A long pseudo-random stream, with patterns planted after line resets, is compared bit by bit against an arithmetic model.

// File: rtl/swd_oob_pkg.sv
package swd_oob_pkg;
   localparam int unsigned DEF_CNT_W     = 8;
   localparam int unsigned DEF_RESET_MIN = 50;
   localparam int unsigned DEF_SEQ_W     = 16;
   localparam logic [15:0] DEF_SEQ_VAL   = 16'hE79E;

   // One sampled debug-clock rising edge
   typedef struct packed {
      logic rise;
      logic bit_val;
   } swd_sample_t;
endpackage

// File: rtl/swd_oob_sampler.sv
module swd_oob_sampler
   import swd_oob_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        swclk_i,
   input  logic        swdio_i,
   output swd_sample_t smp_o
);
   logic clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_q <= 1'b0;
      else        clk_q <= swclk_i;
   end

   always_comb begin
      smp_o.rise    = swclk_i & ~clk_q;
      smp_o.bit_val = swdio_i;
   end
endmodule

// File: rtl/swd_oob_run_counter.sv
module swd_oob_run_counter
   import swd_oob_pkg::*;
#(
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter int unsigned RESET_MIN = DEF_RESET_MIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  swd_sample_t      smp_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] len_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] THRESH  = CNT_W'(RESET_MIN);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (smp_i.rise) begin
         if (!smp_i.bit_val)        cnt_q <= '0;
         else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = smp_i.rise & ~smp_i.bit_val & (cnt_q >= THRESH);
   assign len_o = cnt_q;
endmodule

// File: rtl/swd_oob_seq_matcher.sv
module swd_oob_seq_matcher
   import swd_oob_pkg::*;
#(
   parameter int unsigned     SEQ_W     = DEF_SEQ_W,
   parameter logic [SEQ_W-1:0] SEQ_VAL  = SEQ_W'(DEF_SEQ_VAL),
   parameter bit              LSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  swd_sample_t smp_i,
   input  logic        restart_i,
   output logic        match_o
);
   localparam int unsigned FILL_W = $clog2(SEQ_W + 1);
   localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SEQ_W);

   logic [SEQ_W-1:0]  hist_q, hist_d, shifted, seeded;
   logic [FILL_W-1:0] fill_q, fill_d;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shifted = {smp_i.bit_val, hist_q[SEQ_W-1:1]};
         assign seeded  = {smp_i.bit_val, {(SEQ_W-1){1'b0}}};
      end else begin : g_msb
         assign shifted = {hist_q[SEQ_W-2:0], smp_i.bit_val};
         assign seeded  = {{(SEQ_W-1){1'b0}}, smp_i.bit_val};
      end
   endgenerate

   always_comb begin
      hist_d = hist_q;
      fill_d = fill_q;
      if (smp_i.rise) begin
         if (restart_i) begin
            hist_d = seeded;
            fill_d = FILL_W'(1);
         end else begin
            hist_d = shifted;
            if (fill_q != FILL_FULL) fill_d = fill_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else begin
         hist_q <= hist_d;
         fill_q <= fill_d;
      end
   end

   assign match_o = smp_i.rise & (fill_d == FILL_FULL) & (hist_d == SEQ_VAL);
endmodule

// File: rtl/swd_oob_detect.sv
module swd_oob_detect
   import swd_oob_pkg::*;
#(
   parameter int unsigned      CNT_W     = DEF_CNT_W,
   parameter int unsigned      RESET_MIN = DEF_RESET_MIN,
   parameter int unsigned      SEQ_W     = DEF_SEQ_W,
   parameter logic [SEQ_W-1:0] SEQ_VAL   = SEQ_W'(DEF_SEQ_VAL),
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             swclk_i,
   input  logic             swdio_i,
   output logic             line_reset_o,
   output logic             select_o,
   output logic [CNT_W-1:0] run_len_o
);
   generate
      if (RESET_MIN < 1 || RESET_MIN > (2**CNT_W) - 1) begin : g_bad_thresh
         $error("RESET_MIN must lie in 1 .. 2**CNT_W-1");
      end
      if (SEQ_W < 2) begin : g_bad_seq
         $error("SEQ_W must be at least 2");
      end
   endgenerate

   swd_sample_t      smp;
   logic             hit, match;
   logic [CNT_W-1:0] len;

   swd_oob_sampler u_smp (
      .clk     (clk),
      .rst_n   (rst_n),
      .swclk_i (swclk_i),
      .swdio_i (swdio_i),
      .smp_o   (smp)
   );

   swd_oob_run_counter #(.CNT_W(CNT_W), .RESET_MIN(RESET_MIN)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .smp_i (smp),
      .hit_o (hit),
      .len_o (len)
   );

   swd_oob_seq_matcher #(.SEQ_W(SEQ_W), .SEQ_VAL(SEQ_VAL), .LSB_FIRST(LSB_FIRST)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_i     (smp),
      .restart_i (hit),
      .match_o   (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_reset_o <= 1'b0;
         select_o     <= 1'b0;
         run_len_o    <= '0;
      end else begin
         line_reset_o <= hit;
         select_o     <= match & ~hit;
         if (hit) run_len_o <= len;
      end
   end
endmodule

// File: rtl/swd_oob_detect_chk.sv
module swd_oob_detect_chk #(
   parameter int unsigned      CNT_W     = 8,
   parameter int unsigned      RESET_MIN = 50,
   parameter int unsigned      SEQ_W     = 16,
   parameter logic [SEQ_W-1:0] SEQ_VAL   = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             swclk_i,
   input logic             swdio_i,
   input logic             line_reset_o,
   input logic             select_o,
   input logic [CNT_W-1:0] run_len_o
);
   logic prev_clk_q, low_rise_q, pat_rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk_q <= 1'b0;
         low_rise_q <= 1'b0;
         pat_rise_q <= 1'b0;
      end else begin
         prev_clk_q <= swclk_i;
         low_rise_q <= swclk_i & ~prev_clk_q & ~swdio_i;
         pat_rise_q <= swclk_i & ~prev_clk_q & (swdio_i == SEQ_VAL[SEQ_W-1]);
      end
   end

   // R6
   reset_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_o |=> !line_reset_o);
   // R6
   select_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      select_o |=> !select_o);
   // R7
   no_dual_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_reset_o && select_o));
   // R3
   reset_after_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_o |-> low_rise_q);
   // R5
   select_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      select_o |-> pat_rise_q);
   // R4
   run_len_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_reset_o |-> (run_len_o >= CNT_W'(RESET_MIN)));
   // R4
   run_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_reset_o |-> $stable(run_len_o));
endmodule

bind swd_oob_detect swd_oob_detect_chk #(
   .CNT_W(CNT_W), .RESET_MIN(RESET_MIN), .SEQ_W(SEQ_W), .SEQ_VAL(SEQ_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .swclk_i(swclk_i), .swdio_i(swdio_i),
   .line_reset_o(line_reset_o), .select_o(select_o), .run_len_o(run_len_o)
);

// File: tb/tb_swd_oob_detect.sv
module tb_swd_oob_detect;
   localparam int CLK_PERIOD = 10;
   localparam int THRESH     = 50;
   localparam int CMAX       = 255;
   localparam logic [15:0] PAT = 16'hE79E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       swclk_i = 1'b0;
   logic       swdio_i = 1'b0;
   logic       line_reset_o, select_o;
   logic [7:0] run_len_o;

   int checks = 0;
   int fails  = 0;

   // Reference model state
   int          m_cnt  = 0;
   logic [15:0] m_hist = '0;
   int          m_fill = 0;
   int          m_len  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swd_oob_detect dut (
      .clk(clk), .rst_n(rst_n), .swclk_i(swclk_i), .swdio_i(swdio_i),
      .line_reset_o(line_reset_o), .select_o(select_o), .run_len_o(run_len_o)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One debug-clock period carrying bit b
   task automatic send_bit(input logic b);
      logic e_lr, e_sel;
      @(negedge clk);
      swclk_i = 1'b0;
      swdio_i = b;
      @(negedge clk);
      // R6: the pulse from the previous edge has gone after one cycle
      check(line_reset_o == 1'b0, "R6", int'(line_reset_o), 0);
      check(select_o == 1'b0, "R6", int'(select_o), 0);
      swclk_i = 1'b1;
      // model the edge
      e_lr = (b == 1'b0) && (m_cnt >= THRESH);
      if (e_lr) m_len = m_cnt;
      if (b) m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      else   m_cnt = 0;
      if (e_lr) begin
         m_hist = {b, 15'b0};     // R8
         m_fill = 1;
      end else begin
         m_hist = {b, m_hist[15:1]};
         m_fill = (m_fill == 16) ? 16 : m_fill + 1;
      end
      e_sel = !e_lr && (m_fill == 16) && (m_hist == PAT);
      @(negedge clk);
      check(line_reset_o == e_lr, "R3", int'(line_reset_o), int'(e_lr));
      check(select_o == e_sel, "R5", int'(select_o), int'(e_sel));
      check(int'(run_len_o) == m_len, "R4", int'(run_len_o), m_len);
      // R7: never both
      check(!(line_reset_o && select_o), "R7", int'(select_o), 0);
   endtask

   task automatic send_run(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b1);
   endtask

   task automatic send_pat(input int first, input int last);
      for (int i = first; i <= last; i++) send_bit(PAT[i]);
   endtask

   // R2: toggle data with the debug clock held, no edge happens
   task automatic wiggle(input logic level);
      @(negedge clk);
      swclk_i = level;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         swdio_i = ~swdio_i;
         check(line_reset_o == 1'b0 && select_o == 1'b0, "R2", int'(line_reset_o), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle under reset
      check(line_reset_o == 1'b0 && select_o == 1'b0, "R1", int'(line_reset_o), 0);
      check(run_len_o == 8'd0, "R1", int'(run_len_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_reset_o == 1'b0 && select_o == 1'b0, "R1", int'(select_o), 0);
      check(run_len_o == 8'd0, "R1", int'(run_len_o), 0);

      // R5: 15-bit tail over zero history must not match
      send_pat(1, 15);
      send_bit(1'b0);

      // R3/R4: sweep run lengths around the threshold
      for (int n = 0; n <= 60; n++) begin
         send_run(n);
         send_bit(1'b0);
      end

      // R4: saturation
      send_run(300);
      send_bit(1'b0);

      // R2: data toggling without edges during a high run
      send_run(30);
      wiggle(1'b1);
      wiggle(1'b0);
      swdio_i = 1'b1;
      send_run(20);
      send_bit(1'b0);
      send_run(49);
      wiggle(1'b0);
      send_bit(1'b0);

      // R8: line reset then selection pattern starting on the ending bit
      send_run(55);
      send_pat(0, 15);
      send_run(55);
      send_bit(1'b0);
      // R8: partial pattern before reset must not combine with bits after
      send_pat(0, 7);
      send_run(60);
      send_pat(0, 15);
      send_pat(0, 15);

      // Pseudo-random stream with planted events
      begin
         logic [15:0] lfsr = 16'hACE1;
         for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
            if (k % 300 == 150) begin
               send_run(50 + (k % 7));
               send_pat(0, 15);
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule